// File: doc/BRIEF.md
# Fixed-Priority Interrupt Controller with End-of-Interrupt Handling

This block gathers eight interrupt request lines and raises one interrupt line toward a processor. Each request line is edge sensitive. A rising edge is latched into a pending register and stays there until the processor takes it. A per-line mask hides a pending request from the processor without discarding it. Line 0 has the highest priority and line 7 the lowest.

When the processor acknowledges, the controller picks the most urgent visible request and clears its pending bit. It returns a vector number one cycle later. That vector is a programmable base plus the line number. The line is also recorded as in service. While a line is in service, requests of the same or lower priority are held back. A request of strictly higher priority may still interrupt and nest.

A line leaves service in one of three ways:
- An explicit end-of-interrupt command that names the line.
- An implicit command that retires the most urgent line in service.
- Automatic mode, in which the line is never recorded as in service when the acknowledge is taken.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the interrupt output and the vector-valid output are low, no request is pending, no line is in service, all masks are clear, and the vector base is 0.
- R2: A low-to-high change on a request line sets its pending bit, and the interrupt output reflects it in the cycle after that clock edge. A line held high is not latched again after its request is taken, until it falls and rises again.
- R3: A masked line keeps its pending bit but does not raise the interrupt output. Clearing the mask presents that line.
- R4: Line 0 has the highest priority. An acknowledge takes the lowest-numbered pending, unmasked line and clears only that pending bit.
- R5: When an acknowledge is taken, the vector-valid output is high for exactly the next cycle. The vector output then carries the base plus the line number, modulo 2^VEC_W.
- R6: The interrupt output is high only when the most urgent visible pending line has a lower number than every line in service. Equal or lower priority lines are held back, and a higher one nests.
- R7: An end-of-interrupt command with mode 0 (explicit) clears only the in-service bit at the given level.
- R8: An end-of-interrupt command with mode 1 (implicit) ignores the level input. It clears the lowest-numbered in-service bit.
- R9: With auto mode high, an acknowledge returns a vector but marks no line in service.
- R10: An end-of-interrupt command has no effect when no line is in service. An explicit command that names a line not in service also has no effect.
- R11: An acknowledge while the interrupt output is low changes no state. The vector-valid output stays low.
- R12: An acknowledge and an end-of-interrupt command in the same cycle both take effect. The command acts on the in-service set as it was before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | NUM_LINES | Interrupt request lines, rising-edge detected |
| mask_we | input | 1 | Write strobe for the mask register |
| mask_wdata | input | NUM_LINES | New mask value; 1 hides a line |
| base_we | input | 1 | Write strobe for the vector base |
| base_wdata | input | VEC_W | New vector base |
| auto_eoi | input | 1 | 1 selects automatic end-of-interrupt at acknowledge |
| irq_out | output | 1 | Interrupt request to the processor |
| ack | input | 1 | Processor acknowledge, one cycle per interrupt taken |
| vec_valid | output | 1 | Vector output valid, one cycle after a taken acknowledge |
| vec_out | output | VEC_W | Vector number: base plus line |
| eoi_valid | input | 1 | End-of-interrupt command strobe |
| eoi_mode | input | 1 | 0 explicit (uses eoi_level), 1 implicit (most urgent in service) |
| eoi_level | input | $clog2(NUM_LINES) | Line named by an explicit command |

## Verification
The assertions assume that the acknowledge and end-of-interrupt strobes are synchronous single-cycle pulses. They also assume the acknowledge counts only when the interrupt output is high in that cycle. An acknowledge arriving at any other time is expected to leave the in-service set unchanged, and the checks are written to allow for it. The stimulus drives every input just after a rising edge and holds it until the next one. Acknowledges and commands are mixed freely, both random and overlapping. These include stray acknowledges, commands on empty or clear in-service bits, and mask or base writes in the same cycle as an acknowledge. None of this leaves the assumed protocol, because the block itself defines how it handles each of these cases.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic {
    EOI_NAMED = 1'b0,
    EOI_TOP   = 1'b1
  } eoi_kind_e;
endpackage

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req_in,
  input  logic [N-1:0] take,
  output logic [N-1:0] pend_q
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q[g] <= 1'b0;
        pend_q[g] <= 1'b0;
      end else begin
        prev_q[g] <= req_in[g];
        if (req_in[g] && !prev_q[g])
          pend_q[g] <= 1'b1;
        else if (take[g])
          pend_q[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic [N-1:0]  bits,
  output logic          any,
  output logic [LW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (bits[i]) begin
        any = 1'b1;
        idx = LW'(i);
      end
    end
  end
endmodule

// File: rtl/pic_isr.sv
module pic_isr #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    set_bits,
  input  logic            eoi_valid,
  input  pic_pkg::eoi_kind_e eoi_kind,
  input  logic [LW-1:0]   eoi_level,
  output logic [N-1:0]    isr_q,
  output logic            top_any,
  output logic [LW-1:0]   top_idx
);
  logic [N-1:0] clr_bits;

  pic_prio_enc #(.N(N), .LW(LW)) u_top (
    .bits (isr_q),
    .any  (top_any),
    .idx  (top_idx)
  );

  always_comb begin
    clr_bits = '0;
    if (eoi_valid) begin
      if (eoi_kind == pic_pkg::EOI_NAMED)
        clr_bits = N'(1) << eoi_level;
      else if (top_any)
        clr_bits = N'(1) << top_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) isr_q <= '0;
    else     isr_q <= (isr_q & ~clr_bits) | set_bits;
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NUM_LINES = 8,
  parameter int VEC_W     = 8,
  localparam int LVL_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] req_in,
  input  logic                 mask_we,
  input  logic [NUM_LINES-1:0] mask_wdata,
  input  logic                 base_we,
  input  logic [VEC_W-1:0]     base_wdata,
  input  logic                 auto_eoi,
  output logic                 irq_out,
  input  logic                 ack,
  output logic                 vec_valid,
  output logic [VEC_W-1:0]     vec_out,
  input  logic                 eoi_valid,
  input  logic                 eoi_mode,
  input  logic [LVL_W-1:0]     eoi_level
);
  logic [NUM_LINES-1:0] pend_q, mask_q, vis, take, set_bits, isr_q;
  logic [VEC_W-1:0]     base_q;
  logic                 vis_any, isr_any, taken;
  logic [LVL_W-1:0]     vis_idx, isr_idx;
  pic_pkg::eoi_kind_e   eoi_kind;

  assign eoi_kind = pic_pkg::eoi_kind_e'(eoi_mode);
  assign vis      = pend_q & ~mask_q;

  pic_req_latch #(.N(NUM_LINES)) u_req (
    .clk    (clk),
    .rst    (rst),
    .req_in (req_in),
    .take   (take),
    .pend_q (pend_q)
  );

  pic_prio_enc #(.N(NUM_LINES), .LW(LVL_W)) u_pick (
    .bits (vis),
    .any  (vis_any),
    .idx  (vis_idx)
  );

  pic_isr #(.N(NUM_LINES), .LW(LVL_W)) u_isr (
    .clk       (clk),
    .rst       (rst),
    .set_bits  (set_bits),
    .eoi_valid (eoi_valid),
    .eoi_kind  (eoi_kind),
    .eoi_level (eoi_level),
    .isr_q     (isr_q),
    .top_any   (isr_any),
    .top_idx   (isr_idx)
  );

  // A visible request is eligible only if it outranks every line in service.
  assign irq_out = vis_any && (!isr_any || (vis_idx < isr_idx));
  assign taken   = ack && irq_out;

  always_comb begin
    take     = '0;
    set_bits = '0;
    if (taken) begin
      take = NUM_LINES'(1) << vis_idx;
      if (!auto_eoi) set_bits = NUM_LINES'(1) << vis_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q    <= '0;
      base_q    <= '0;
      vec_valid <= 1'b0;
      vec_out   <= '0;
    end else begin
      if (mask_we) mask_q <= mask_wdata;
      if (base_we) base_q <= base_wdata;
      vec_valid <= taken;
      if (taken) vec_out <= base_q + VEC_W'(vis_idx);
    end
  end
endmodule

// File: rtl/pic_chk.sv
module pic_chk #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input logic          clk,
  input logic          rst,
  input logic          ack,
  input logic          irq_out,
  input logic          vec_valid,
  input logic          auto_eoi,
  input logic          eoi_valid,
  input logic          eoi_mode,
  input logic [LW-1:0] eoi_level,
  input logic [N-1:0]  isr_q,
  input logic [N-1:0]  vis
);
  // R6: the interrupt is only raised with a visible pending request
  a_r6_irq_needs_pending: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> (vis != '0));

  // R5: a taken acknowledge yields a valid vector next cycle
  a_r5_vec_follows_ack: assert property (@(posedge clk) disable iff (rst)
    (ack && irq_out) |=> vec_valid);

  // R11: no vector without a taken acknowledge
  a_r11_no_stray_vec: assert property (@(posedge clk) disable iff (rst)
    !(ack && irq_out) |=> !vec_valid);

  // R9: auto mode leaves the in-service set untouched on acknowledge
  a_r9_auto_no_isr: assert property (@(posedge clk) disable iff (rst)
    (auto_eoi && ack && irq_out && !eoi_valid) |=> (isr_q == $past(isr_q)));

  // R10: explicit command on a clear bit does nothing
  a_r10_eoi_clear_bit: assert property (@(posedge clk) disable iff (rst)
    (eoi_valid && !eoi_mode && !isr_q[eoi_level] && !(ack && irq_out))
      |=> (isr_q == $past(isr_q)));

  // R8: implicit command retires exactly one in-service line
  a_r8_implicit_one: assert property (@(posedge clk) disable iff (rst)
    (eoi_valid && eoi_mode && (isr_q != '0) && !(ack && irq_out))
      |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));
endmodule

bind prio_irq_ctrl pic_chk #(.N(NUM_LINES), .LW(LVL_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ack       (ack),
  .irq_out   (irq_out),
  .vec_valid (vec_valid),
  .auto_eoi  (auto_eoi),
  .eoi_valid (eoi_valid),
  .eoi_mode  (eoi_mode),
  .eoi_level (eoi_level),
  .isr_q     (isr_q),
  .vis       (vis)
);

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;
  localparam int N = 8;
  localparam int VW = 8;
  localparam int LW = $clog2(N);

  logic          clk = 0;
  logic          rst = 1;
  logic [N-1:0]  req_in = '0;
  logic          mask_we = 0;
  logic [N-1:0]  mask_wdata = '0;
  logic          base_we = 0;
  logic [VW-1:0] base_wdata = '0;
  logic          auto_eoi = 0;
  logic          irq_out;
  logic          ack = 0;
  logic          vec_valid;
  logic [VW-1:0] vec_out;
  logic          eoi_valid = 0;
  logic          eoi_mode = 0;
  logic [LW-1:0] eoi_level = '0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [N-1:0]  irr_m, isr_m, mask_m, prev_m;
  logic [VW-1:0] base_m, exp_vec;
  logic          exp_vv;

  always #4 clk = ~clk;

  prio_irq_ctrl #(.NUM_LINES(N), .VEC_W(VW)) i_prio_irq_ctrl (
    .clk(clk), .rst(rst), .req_in(req_in), .mask_we(mask_we),
    .mask_wdata(mask_wdata), .base_we(base_we), .base_wdata(base_wdata),
    .auto_eoi(auto_eoi), .irq_out(irq_out), .ack(ack),
    .vec_valid(vec_valid), .vec_out(vec_out), .eoi_valid(eoi_valid),
    .eoi_mode(eoi_mode), .eoi_level(eoi_level)
  );

  function automatic int lowest(input logic [N-1:0] b);
    for (int i = 0; i < N; i++) if (b[i]) return i;
    return N;
  endfunction

  function automatic logic exp_irq();
    int lp = lowest(irr_m & ~mask_m);
    return (lp < N) && (lp < lowest(isr_m));
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag);
    logic [N-1:0] clr, setb, tk;
    int hp, hi;
    logic elig;
    @(posedge clk);
    hp = lowest(irr_m & ~mask_m);
    hi = lowest(isr_m);
    elig = (hp < N) && (hp < hi);
    clr = '0; setb = '0; tk = '0;
    if (eoi_valid) begin
      if (!eoi_mode) clr[eoi_level] = 1'b1;
      else if (hi < N) clr[hi] = 1'b1;
    end
    exp_vv = 1'b0;
    if (ack && elig) begin
      tk[hp] = 1'b1;
      if (!auto_eoi) setb[hp] = 1'b1;
      exp_vv = 1'b1;
      exp_vec = base_m + VW'(hp);
    end
    isr_m = (isr_m & ~clr) | setb;
    irr_m = (irr_m & ~tk) | (req_in & ~prev_m);
    prev_m = req_in;
    if (mask_we) mask_m = mask_wdata;
    if (base_we) base_m = base_wdata;
    #1;
    check(tag, "irq_out", int'(irq_out), int'(exp_irq()));
    check(tag, "vec_valid", int'(vec_valid), int'(exp_vv));
    if (exp_vv) check(tag, "vec_out", int'(vec_out), int'(exp_vec));
    ack = 0; eoi_valid = 0; mask_we = 0; base_we = 0;
  endtask

  task automatic do_ack(input string tag);
    ack = 1; step(tag);
  endtask

  task automatic do_eoi(input string tag, input logic md, input int lvl);
    eoi_valid = 1; eoi_mode = md; eoi_level = LW'(lvl); step(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    irr_m = '0; isr_m = '0; mask_m = '0; prev_m = '0; base_m = '0;
    exp_vec = '0; exp_vv = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1: reset state
    check("R1", "irq_out", int'(irq_out), 0);
    check("R1", "vec_valid", int'(vec_valid), 0);
    base_we = 1; base_wdata = 8'h20; step("R1");

    req_in[5] = 1; step("R2");              // edge latched
    do_ack("R5");                            // vector 0x25
    step("R2"); step("R2");                  // held high, no relatch
    req_in[6] = 1; step("R6");              // lower priority blocked
    req_in[2] = 1; step("R6");              // higher nests
    do_ack("R4");                            // vector 0x22
    do_eoi("R8", 1'b1, 7);                   // clears line 2
    do_eoi("R10", 1'b0, 3);                  // clear bit, no effect
    step("R10");
    do_eoi("R7", 1'b0, 5);                   // releases 6
    do_ack("R5");
    do_eoi("R8", 1'b1, 0);
    mask_we = 1; mask_wdata = 8'h02; step("R3");
    req_in[1] = 1; step("R3");              // masked, latched
    step("R3");
    mask_we = 1; mask_wdata = 8'h00; step("R3");
    do_ack("R4");
    do_eoi("R7", 1'b0, 1);
    do_eoi("R10", 1'b1, 4);                  // empty in-service
    do_ack("R11");                           // stray acknowledge
    req_in = '0; step("R2");
    auto_eoi = 1;
    req_in[4] = 1; step("R9");
    do_ack("R9");
    req_in[7] = 1; step("R9");              // not blocked by 4
    do_ack("R9");
    auto_eoi = 0; req_in = '0; step("R9");
    req_in[3] = 1; step("R12");
    do_ack("R12");
    req_in[1] = 1; step("R12");
    ack = 1; eoi_valid = 1; eoi_mode = 0; eoi_level = 3; step("R12");
    req_in[2] = 1; step("R12");             // blocked by 1
    do_eoi("R12", 1'b0, 1);
    do_ack("R12");
    do_eoi("R8", 1'b1, 0);
    req_in = '0; base_we = 1; base_wdata = 8'hFE; step("R5");
    req_in[7] = 1; step("R5");
    do_ack("R5");                            // wraps to 0x05
    do_eoi("R7", 1'b0, 7);

    for (int c = 0; c < 4000; c++) begin
      for (int b = 0; b < N; b++)
        if ($urandom_range(0, 5) == 0) req_in[b] = ~req_in[b];
      ack = ($urandom_range(0, 2) == 0);
      eoi_valid = ($urandom_range(0, 3) == 0);
      eoi_mode = 1'($urandom_range(0, 1));
      eoi_level = LW'($urandom_range(0, N - 1));
      mask_we = ($urandom_range(0, 30) == 0);
      mask_wdata = N'($urandom) & N'($urandom);
      base_we = ($urandom_range(0, 60) == 0);
      base_wdata = VW'($urandom);
      if ($urandom_range(0, 100) == 0) auto_eoi = ~auto_eoi;
      step("R4");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule